// File: doc/BRIEF.md
# Bank Controller with Latched Calendar Clock

This block sits between a CPU write bus and a banked cartridge memory. It keeps a 7-bit ROM bank number, a 2-bit external RAM bank number and an enable for the external RAM window. It also contains a calendar clock with seconds, minutes, hours and a 9-bit day count. The clock has a halt control and a sticky day-overflow flag.

The register that selects the RAM bank is shared with the clock. Some of its values pick a RAM bank. Other values map one of five clock registers into the external RAM window (address bits [15:13] = 5). The running counters advance on a one-pulse-per-second tick input. The CPU does not see them directly. It reads a latched copy, which is refreshed only when it writes 0 and then 1 to the latch register. Writes to the window while clock mode is on load the running counter that is selected.

Top module: `rtc_bank_ctrl`

## Requirements
- R1: A write to region 0 (wrAddr[15:13]=0) of 0x0A sets ramEn and a write of 0x00 clears it. Any other value leaves ramEn unchanged.
- R2: A write to region 1 loads romBank with wrData[6:0]. A value of 0 loads bank 1 instead.
- R3: A write to region 2 with a value of 0 to 3 loads ramBank and clears rtcSel. A value of 0x08 to 0x0C selects clock register (value-8) and sets rtcSel, leaving ramBank unchanged. Every other value changes nothing.
- R4: In region 3, a write of 0x01 while unlatched copies all running counters into the readable registers and sets the latched flag. A write of 0x00 while latched clears the flag. Every other write, including 0x01 while latched, changes neither the flag nor the readable registers. Ticks never change the readable registers.
- R5: On each tick, seconds advance. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day count.
- R6: The day count is 9 bits wide. Clock register 3 holds its low 8 bits, and bit 0 of clock register 4 holds its bit 8.
- R7: When the day count advances past 511 it becomes 0 and bit 7 of register 4 is set. That bit stays set until a load of register 4 writes it.
- R8: While bit 6 of register 4 (halt) is 1, ticks do not change the counters.
- R9: A write to the window while ramEn and rtcSel are set loads the selected counter. Register 0 takes seconds from data[5:0]. Register 1 takes minutes from data[5:0]. Register 2 takes hours from data[4:0]. Register 3 takes the low 8 bits of the day count. Register 4 takes day bit 8 from data[0], halt from data[6] and overflow from data[7]. If a load and a tick arrive in the same cycle, the load wins and the tick is dropped.
- R10: rdData shows the latched copy of the selected clock register when ramEn and rtcSel are set and rdAddr[15:13]=5. Otherwise it is 0xFF. Unused register bits read as 0.
- R11: After reset, romBank=1, ramBank=0, ramEn=0 and rtcSel=0. All counters, the latched copies and the latched flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | CPU write strobe, one cycle |
| wrAddr | input | 16 | CPU write address |
| wrData | input | 8 | CPU write data |
| rdAddr | input | 16 | CPU read address |
| tick | input | 1 | One pulse per second |
| romBank | output | 7 | Switchable ROM bank number |
| ramBank | output | 2 | External RAM bank number |
| ramEn | output | 1 | External RAM / clock window enabled |
| rtcSel | output | 1 | Window maps a clock register |
| rdData | output | 8 | Latched clock register read data |

## Verification
The running counters are visible only through a latch. A wrong carry, wrap, halt or load therefore appears at rdData only after the next 0-then-1 latch sequence, and not before. A broken latch flag shows up differently: the readable registers either fail to refresh or change when they should hold. The bench latches right after each stimulus so that any such fault appears a few cycles later. Bank and select faults appear at romBank, ramBank, rtcSel or ramEn on the cycle after the write.

// File: rtl/rtc_bank_pkg.sv
package rtc_bank_pkg;
  localparam int REGION_ENABLE = 0;
  localparam int REGION_ROM    = 1;
  localparam int REGION_SELECT = 2;
  localparam int REGION_LATCH  = 3;
  localparam int REGION_WINDOW = 5;
  localparam int CLK_REGS      = 5;

  typedef struct packed {
    logic       latchStb;
    logic       loadStb;
    logic [2:0] loadSel;
    logic [7:0] loadData;
  } rtcStrobes_t;
endpackage

// File: rtl/rtc_bank_control.sv
module rtc_bank_control
  import rtc_bank_pkg::*;
#(
  parameter int ROM_BITS = 7,
  parameter int RAM_BITS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [2:0]          wrRegion,
  input  logic [7:0]          wrData,
  output logic [ROM_BITS-1:0] romBank,
  output logic [RAM_BITS-1:0] ramBank,
  output logic                ramEn,
  output logic                rtcSel,
  output logic [2:0]          selIdx,
  output rtcStrobes_t         strb
);
  localparam int RAM_BANKS = 1 << RAM_BITS;
  localparam logic [7:0] SEL_FIRST = 8'h08;
  localparam logic [7:0] SEL_LAST  = SEL_FIRST + 8'(CLK_REGS - 1);

  logic latched;
  logic isSelClock;
  logic isSelRam;
  logic [7:0] selOffset;

  assign isSelRam   = wrData < 8'(RAM_BANKS);
  assign isSelClock = (wrData >= SEL_FIRST) && (wrData <= SEL_LAST);
  assign selOffset  = wrData - SEL_FIRST;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      romBank <= ROM_BITS'(1);
      ramBank <= '0;
      ramEn   <= 1'b0;
      rtcSel  <= 1'b0;
      selIdx  <= '0;
      latched <= 1'b0;
    end else if (wrEn) begin
      case (int'(wrRegion))
        REGION_ENABLE: begin
          if (wrData == 8'h0A) ramEn <= 1'b1;
          else if (wrData == 8'h00) ramEn <= 1'b0;
        end
        REGION_ROM: begin
          if (wrData[ROM_BITS-1:0] == '0) romBank <= ROM_BITS'(1);
          else romBank <= wrData[ROM_BITS-1:0];
        end
        REGION_SELECT: begin
          if (isSelRam) begin
            ramBank <= wrData[RAM_BITS-1:0];
            rtcSel  <= 1'b0;
          end else if (isSelClock) begin
            selIdx <= selOffset[2:0];
            rtcSel <= 1'b1;
          end
        end
        REGION_LATCH: begin
          if (latched && wrData == 8'h00) latched <= 1'b0;
          else if (!latched && wrData == 8'h01) latched <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.latchStb = wrEn && (int'(wrRegion) == REGION_LATCH) && !latched && (wrData == 8'h01);
    strb.loadStb  = wrEn && (int'(wrRegion) == REGION_WINDOW) && ramEn && rtcSel;
    strb.loadSel  = selIdx;
    strb.loadData = wrData;
  end
endmodule

// File: rtl/rtc_bank_datapath.sv
module rtc_bank_datapath
  import rtc_bank_pkg::*;
#(
  parameter int SEC_LIMIT  = 60,
  parameter int MIN_LIMIT  = 60,
  parameter int HOUR_LIMIT = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  rtcStrobes_t strb,
  input  logic        readOpen,
  input  logic [2:0]  selIdx,
  output logic [7:0]  rdData
);
  localparam int DAY_BITS = 9;
  localparam logic [DAY_BITS-1:0] DAY_LAST = '1;

  logic [5:0] sec, min;
  logic [4:0] hour;
  logic [DAY_BITS-1:0] day;
  logic halt, dayCarry;
  logic secWrap, minWrap, hourWrap, dayWrap;
  logic [7:0] curView [CLK_REGS];
  logic [7:0] latView [CLK_REGS];

  assign secWrap  = int'(sec) >= SEC_LIMIT - 1;
  assign minWrap  = secWrap && (int'(min) >= MIN_LIMIT - 1);
  assign hourWrap = minWrap && (int'(hour) >= HOUR_LIMIT - 1);
  assign dayWrap  = hourWrap && (day == DAY_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sec <= '0; min <= '0; hour <= '0; day <= '0;
      halt <= 1'b0; dayCarry <= 1'b0;
    end else if (strb.loadStb) begin
      case (strb.loadSel)
        3'd0: sec  <= strb.loadData[5:0];
        3'd1: min  <= strb.loadData[5:0];
        3'd2: hour <= strb.loadData[4:0];
        3'd3: day[7:0] <= strb.loadData;
        3'd4: begin
          day[8]   <= strb.loadData[0];
          halt     <= strb.loadData[6];
          dayCarry <= strb.loadData[7];
        end
        default: ;
      endcase
    end else if (tick && !halt) begin
      sec <= secWrap ? '0 : sec + 6'd1;
      if (secWrap) min <= minWrap ? '0 : min + 6'd1;
      if (minWrap) hour <= hourWrap ? '0 : hour + 5'd1;
      if (hourWrap) day <= day + 1'b1;
      if (dayWrap) dayCarry <= 1'b1;
    end
  end

  always_comb begin
    curView[0] = {2'b00, sec};
    curView[1] = {2'b00, min};
    curView[2] = {3'b000, hour};
    curView[3] = day[7:0];
    curView[4] = {dayCarry, halt, 5'b00000, day[8]};
  end

  for (genvar g = 0; g < CLK_REGS; g++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (!rstN) latView[g] <= '0;
      else if (strb.latchStb) latView[g] <= curView[g];
    end
  end

  always_comb begin
    rdData = 8'hFF;
    if (readOpen && int'(selIdx) < CLK_REGS) rdData = latView[selIdx];
  end
endmodule

// File: rtl/rtc_bank_ctrl.sv
module rtc_bank_ctrl
  import rtc_bank_pkg::*;
#(
  parameter int ROM_BITS = 7,
  parameter int RAM_BITS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [15:0]         wrAddr,
  input  logic [7:0]          wrData,
  input  logic [15:0]         rdAddr,
  input  logic                tick,
  output logic [ROM_BITS-1:0] romBank,
  output logic [RAM_BITS-1:0] ramBank,
  output logic                ramEn,
  output logic                rtcSel,
  output logic [7:0]          rdData
);
  rtcStrobes_t strb;
  logic [2:0] selIdx;
  logic readOpen;
  logic unusedAddrBits;

  assign unusedAddrBits = ^{wrAddr[12:0], rdAddr[12:0]};
  assign readOpen = ramEn && rtcSel && (int'(rdAddr[15:13]) == REGION_WINDOW);

  rtc_bank_control #(.ROM_BITS(ROM_BITS), .RAM_BITS(RAM_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrRegion(wrAddr[15:13]),
    .wrData(wrData), .romBank(romBank), .ramBank(ramBank), .ramEn(ramEn),
    .rtcSel(rtcSel), .selIdx(selIdx), .strb(strb)
  );

  rtc_bank_datapath u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .strb(strb),
    .readOpen(readOpen), .selIdx(selIdx), .rdData(rdData)
  );
endmodule

// File: rtl/rtc_bank_ctrl_chk.sv
module rtc_bank_ctrl_chk
  import rtc_bank_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [15:0] wrAddr,
  input logic [7:0]  wrData,
  input logic [15:0] rdAddr,
  input logic [6:0]  romBank,
  input logic [1:0]  ramBank,
  input logic        ramEn,
  input logic        rtcSel,
  input logic [7:0]  rdData,
  input rtcStrobes_t strb
);
  logic unusedChk;
  assign unusedChk = ^{wrAddr[12:0], rdAddr[12:0], strb.loadSel, strb.loadData, strb.loadStb};

  p_disable_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr[15:13] == 3'd0 && wrData == 8'h00) |=> !ramEn);

  p_rom_nonzero_r2: assert property (@(posedge clk) disable iff (!rstN)
    romBank != 7'd0);

  p_clocksel_keeps_ram_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr[15:13] == 3'd2 && wrData >= 8'h08 && wrData <= 8'h0C)
      |=> (rtcSel && ramBank == $past(ramBank)));

  p_latch_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchStb |-> (wrEn && wrAddr[15:13] == 3'd3 && wrData == 8'h01));

  p_idle_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(ramEn && rtcSel && rdAddr[15:13] == 3'd5) |-> rdData == 8'hFF);
endmodule

bind rtc_bank_ctrl rtc_bank_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rdAddr(rdAddr), .romBank(romBank), .ramBank(ramBank), .ramEn(ramEn),
  .rtcSel(rtcSel), .rdData(rdData), .strb(strb)
);

// File: tb/rtc_bank_ctrl_test.sv
module rtc_bank_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [15:0] rdAddr = 16'hA000;
  logic tick = 1'b0;
  logic [6:0] romBank;
  logic [1:0] ramBank;
  logic ramEn, rtcSel;
  logic [7:0] rdData;
  int errCnt = 0;
  int chkCnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_bank_ctrl uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .tick(tick), .romBank(romBank), .ramBank(ramBank),
    .ramEn(ramEn), .rtcSel(rtcSel), .rdData(rdData)
  );

  // {addr, data, romBank, ramBank, rtcSel, ramEn, requirement number}
  localparam logic [39:0] VEC [10] = '{
    {16'h0000, 8'h0A, 7'd1, 2'd0, 1'b0, 1'b1, 5'd1},  // R1 enable
    {16'h0000, 8'h55, 7'd1, 2'd0, 1'b0, 1'b1, 5'd1},  // R1 other value ignored
    {16'h2000, 8'h00, 7'd1, 2'd0, 1'b0, 1'b1, 5'd2},  // R2 zero maps to 1
    {16'h2000, 8'h85, 7'd5, 2'd0, 1'b0, 1'b1, 5'd2},  // R2 bit 7 dropped
    {16'h4000, 8'h03, 7'd5, 2'd3, 1'b0, 1'b1, 5'd3},  // R3 RAM bank
    {16'h4000, 8'h05, 7'd5, 2'd3, 1'b0, 1'b1, 5'd3},  // R3 ignored value
    {16'h4000, 8'h08, 7'd5, 2'd3, 1'b1, 1'b1, 5'd3},  // R3 clock select
    {16'h4000, 8'h0D, 7'd5, 2'd3, 1'b1, 1'b1, 5'd3},  // R3 ignored value
    {16'h4000, 8'h02, 7'd5, 2'd2, 1'b0, 1'b1, 5'd3},  // R3 back to RAM
    {16'h0000, 8'h00, 7'd5, 2'd2, 1'b0, 1'b0, 5'd1}   // R1 disable
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wrAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic doLatch();
    wr(16'h6000, 8'h00);
    wr(16'h6000, 8'h01);
  endtask

  task automatic load(input int k, input logic [7:0] d);
    wr(16'h4000, 8'(8 + k));
    wr(16'hA000, d);
  endtask

  task automatic readReg(input int k, input int exp, input string tag);
    wr(16'h4000, 8'(8 + k));
    chk(rdData == 8'(exp), tag, rdData, exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errCnt++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errCnt, chkCnt + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(romBank == 7'd1, "R11 romBank", romBank, 1);
    chk(ramBank == 2'd0, "R11 ramBank", ramBank, 0);
    chk(!ramEn && !rtcSel, "R11 ramEn/rtcSel", {ramEn, rtcSel}, 0);
    chk(rdData == 8'hFF, "R10 closed window", rdData, 8'hFF);

    foreach (VEC[i]) begin
      wr(VEC[i][39:24], VEC[i][23:16]);
      chk(romBank == VEC[i][15:9], $sformatf("R%0d romBank step %0d", VEC[i][4:0], i), romBank, VEC[i][15:9]);
      chk(ramBank == VEC[i][8:7], $sformatf("R%0d ramBank step %0d", VEC[i][4:0], i), ramBank, VEC[i][8:7]);
      chk(rtcSel == VEC[i][6], $sformatf("R%0d rtcSel step %0d", VEC[i][4:0], i), rtcSel, VEC[i][6]);
      chk(ramEn == VEC[i][5], $sformatf("R%0d ramEn step %0d", VEC[i][4:0], i), ramEn, VEC[i][5]);
    end

    // R9 loads, R5/R6 carry chain
    wr(16'h0000, 8'h0A);
    load(0, 8'd58); load(1, 8'd59); load(2, 8'd23);
    load(3, 8'hFF); load(4, 8'h01);
    ticks(1);
    doLatch();
    readReg(0, 59, "R5 seconds advance");
    readReg(1, 59, "R9 minutes load");
    readReg(2, 23, "R9 hours load");
    readReg(3, 8'hFF, "R6 day low byte");
    readReg(4, 8'h01, "R6 day bit 8");
    ticks(1);
    doLatch();
    readReg(0, 0, "R5 seconds wrap");
    readReg(1, 0, "R5 minutes wrap");
    readReg(2, 0, "R5 hours wrap");
    readReg(3, 0, "R7 day wraps");
    readReg(4, 8'h80, "R7 overflow set");

    // R4 latch holds against ticks and repeated 1
    ticks(2);
    readReg(0, 0, "R4 held across ticks");
    wr(16'h6000, 8'h01);
    readReg(0, 0, "R4 second 1 ignored");
    doLatch();
    readReg(0, 2, "R4 relatch");
    readReg(4, 8'h80, "R7 sticky");
    load(4, 8'h00);
    doLatch();
    readReg(4, 8'h00, "R7 cleared by load");

    // R8 halt
    load(4, 8'h40);
    ticks(3);
    doLatch();
    readReg(0, 2, "R8 halted seconds");
    readReg(4, 8'h40, "R8 halt bit");
    load(4, 8'h00);

    // R9 load beats tick
    wr(16'h4000, 8'h08);
    @(negedge clk);
    wrAddr = 16'hA000; wrData = 8'd10; wrEn = 1'b1; tick = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; tick = 1'b0;
    doLatch();
    readReg(0, 10, "R9 load priority");

    // R10 read gating
    rdAddr = 16'h4000;
    @(negedge clk);
    chk(rdData == 8'hFF, "R10 outside window", rdData, 8'hFF);
    rdAddr = 16'hA000;
    wr(16'h4000, 8'h00);
    chk(rdData == 8'hFF, "R10 RAM mode", rdData, 8'hFF);

    // R11 reset mid-run
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(romBank == 7'd1 && !ramEn && !rtcSel, "R11 reset again", {romBank, ramEn, rtcSel}, 8'h04);
    wr(16'h0000, 8'h0A);
    readReg(0, 0, "R11 latched copy cleared");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule